// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is a single DMA channel that walks a linked list of four-word descriptors held in memory. Software places descriptors in memory, writes the address of the first one into the pointer register and sets the run bit. The channel then fetches the descriptor over its memory master port and copies the programmed number of bytes, one 32-bit word at a time. Each word is a read from the source address followed by a write to the target address. When the byte count reaches zero, the channel either stops or fetches the next descriptor. A list whose last entry points back to an earlier entry makes the channel loop until software halts it.

Peripheral transfers use a flow-control request input. When a descriptor asks for flow control, the channel moves one burst only after it sees that input high. The current source, target and remaining length stay readable during a transfer, so software can work out how far the transfer has progressed. Interrupt flags are cleared by writing 1 to them, so writing back a value just read clears whatever was set.

Top module: `dchain_top`

## Requirements
- R1: After reset, the control word (register index 0) reads 0x0000_0008, meaning only the stopped flag in bit 3 is set. After reset, `irq` and `mem_req` are low. The register indices are: 0 control, 1 descriptor pointer, 2 source, 3 target, 4 command.
- R2: Writing the control word with bit 31 (run) at 1 and bit 30 (no-fetch) at 0 starts a fetch when the channel is stopped. The fetch reads four words at address {pointer[31:4], 4'b0}: the next pointer, then source, then target, then command. These load registers 1, 2, 3 and 4.
- R3: A memory request holds its address stable until it is acknowledged. Each word moved is one read at the source address, then one write of the same data to the target address.
- R4: After each word, command bit 31 adds 4 to the source and command bit 30 adds 4 to the target. When the bit is clear, that address stays fixed. The length field, command[12:0], drops by 4 per word. Lengths are multiples of 4. The width field (bits 15:14) and the endian bit (bit 18) do not change the data movement.
- R5: When the length reaches 0, the channel checks bit 0 of the next pointer. If that bit is set, the channel stops: the control word bit 31 reads 0 and bit 3 reads 1. Otherwise it fetches the descriptor at the next pointer.
- R6: The end flag (control bit 2) sets when a descriptor whose command bit 21 is set completes. The start flag (control bit 1) sets when a descriptor whose command bit 22 is set is loaded. Writing 1 to a flag clears it and writing 0 leaves it unchanged. If a flag is set and cleared in the same cycle, the set wins. `irq` is high while any flag is set.
- R7: When command bit 29 or bit 28 is set, the channel waits for `dreq` high before each burst. Command bits 17:16 give the burst size: 0 is 1 word, 1 is 2 words, 2 is 4 words and 3 is 8 words. Control bit 8 shows `dreq` live.
- R8: A list whose next pointers form a loop keeps the channel running. The end flag sets again after every descriptor in the loop that has command bit 21 set.
- R9: Writing the control word with bit 31 at 0 while the channel runs halts it. From the next cycle on, no memory request is made and bit 3 reads 1.
- R10: Setting run with no-fetch (control bit 30) at 1 moves one transfer using registers 2, 3 and 4 directly. The channel then stops without fetching, and the pointer register keeps its value.
- R11: An error response on any memory request sets the bus-error flag (control bit 0) and stops the channel.
- R12: Writes to registers 1 through 4 are ignored while the channel runs. The source and target registers read their live values during a transfer.
- R13: While control bit 29 (stop-interrupt enable) is set and the channel is stopped, `irq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| dreq | input | 1 | Peripheral flow-control request |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; completes the request this cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| irq | output | 1 | Interrupt output |

## Verification
The bench builds the block with the package's fixed 32-bit word and 13-bit length field. It pairs the block with a 1024-word memory that can be given a pseudo-random acknowledge stall. The stall pattern exercises held requests during descriptor fetch and data moves. An error region at the top half of the address space reaches both the fetch and the data-read bus-error paths. A behavioural model queues every expected target write from the descriptor chain and matches each write as it happens. This covers fixed-address targets, three-descriptor chains, a looping chain and burst-by-burst flow control.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
    localparam int WORD_W  = 32;
    localparam int LEN_W   = 13;
    localparam int WORD_B  = WORD_W / 8;
    localparam int IDX_W   = 2;

    // command word fields
    localparam int CB_INC_SRC  = 31;
    localparam int CB_INC_TGT  = 30;
    localparam int CB_FLOW_SRC = 29;
    localparam int CB_FLOW_TGT = 28;
    localparam int CB_START_IE = 22;
    localparam int CB_END_IE   = 21;
    localparam int CB_BURST_LO = 16;

    // control/status word fields
    localparam int SB_RUN     = 31;
    localparam int SB_NOFETCH = 30;
    localparam int SB_STOP_IE = 29;
    localparam int SB_REQ     = 8;
    localparam int SB_STOPPED = 3;
    localparam int SB_END     = 2;
    localparam int SB_START   = 1;
    localparam int SB_BUSERR  = 0;

    // register indices
    localparam logic [2:0] RSEL_CTRL = 3'd0;
    localparam logic [2:0] RSEL_PTR  = 3'd1;
    localparam logic [2:0] RSEL_SRC  = 3'd2;
    localparam logic [2:0] RSEL_TGT  = 3'd3;
    localparam logic [2:0] RSEL_CMD  = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_CHECK, ST_READ, ST_WRITE, ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic set_start;
        logic set_end;
        logic set_buserr;
    } evt_t;

    typedef struct packed {
        logic run;
        logic nofetch;
        logic stop_ie;
        logic clr_end;
        logic clr_start;
        logic clr_buserr;
    } ctrl_wr_t;

    function automatic logic [3:0] burst_words(input logic [1:0] code);
        case (code)
            2'd1:    return 4'd2;
            2'd2:    return 4'd4;
            2'd3:    return 4'd8;
            default: return 4'd1;
        endcase
    endfunction
endpackage

// File: rtl/dchain_csr.sv
module dchain_csr
    import dchain_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  ctrl_wr_t          wbits,
    input  logic              busy,
    input  logic              dreq,
    input  evt_t              evt,
    output logic              go,
    output logic              halt,
    output logic              nofetch_eff,
    output logic [WORD_W-1:0] ctrl_word,
    output logic              irq
);
    logic nofetch_q, stop_ie_q;
    logic fl_end, fl_start, fl_buserr;

    assign go          = wr_ctrl && wbits.run && !busy;
    assign halt        = wr_ctrl && !wbits.run && busy;
    assign nofetch_eff = wr_ctrl ? wbits.nofetch : nofetch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nofetch_q <= 1'b0;
            stop_ie_q <= 1'b0;
            fl_end    <= 1'b0;
            fl_start  <= 1'b0;
            fl_buserr <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                nofetch_q <= wbits.nofetch;
                stop_ie_q <= wbits.stop_ie;
            end
            fl_end    <= evt.set_end    | (fl_end    & ~(wr_ctrl & wbits.clr_end));
            fl_start  <= evt.set_start  | (fl_start  & ~(wr_ctrl & wbits.clr_start));
            fl_buserr <= evt.set_buserr | (fl_buserr & ~(wr_ctrl & wbits.clr_buserr));
        end
    end

    always_comb begin
        ctrl_word              = '0;
        ctrl_word[SB_RUN]      = busy;
        ctrl_word[SB_NOFETCH]  = nofetch_q;
        ctrl_word[SB_STOP_IE]  = stop_ie_q;
        ctrl_word[SB_REQ]      = dreq;
        ctrl_word[SB_STOPPED]  = !busy;
        ctrl_word[SB_END]      = fl_end;
        ctrl_word[SB_START]    = fl_start;
        ctrl_word[SB_BUSERR]   = fl_buserr;
    end

    assign irq = fl_end | fl_start | fl_buserr | (stop_ie_q & !busy);

    // R6: a completion with end-interrupt enable leaves the flag set
    p_end_flag_r6: assert property (@(posedge clk) disable iff (rst)
        evt.set_end |=> fl_end);
    // R6: write-one clears the flag when no new event lands
    p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && wbits.clr_end && !evt.set_end) |=> !fl_end);
    // R9: a halt request leaves the channel stopped on the next cycle
    p_halt_r9: assert property (@(posedge clk) disable iff (rst)
        halt |=> !busy);
endmodule

// File: rtl/dchain_seq.sv
module dchain_seq
    import dchain_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              halt,
    input  logic              nofetch,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              dreq,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              busy,
    output logic [WORD_W-1:0] ptr_q,
    output logic [WORD_W-1:0] src_q,
    output logic [WORD_W-1:0] tgt_q,
    output logic [WORD_W-1:0] cmd_q,
    output evt_t              evt
);
    localparam logic [LEN_W-1:0]  LEN_STEP  = LEN_W'(WORD_B);
    localparam logic [WORD_W-1:0] ADDR_STEP = WORD_W'(WORD_B);

    seq_state_t        st;
    logic [IDX_W-1:0]  widx;
    logic [WORD_W-1:0] fbase;
    logic [WORD_W-1:0] data_q;
    logic [3:0]        bleft;
    logic [LEN_W-1:0]  len;
    logic              flow;
    logic              sw_wr;

    assign len   = cmd_q[LEN_W-1:0];
    assign flow  = cmd_q[CB_FLOW_SRC] | cmd_q[CB_FLOW_TGT];
    assign sw_wr = reg_we && (st == ST_IDLE);
    assign busy  = (st != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            widx   <= '0;
            fbase  <= '0;
            data_q <= '0;
            bleft  <= '0;
            ptr_q  <= '0;
            src_q  <= '0;
            tgt_q  <= '0;
            cmd_q  <= '0;
        end else if (halt) begin
            st <= ST_IDLE;
        end else begin
            if (sw_wr) begin
                case (reg_sel)
                    RSEL_PTR: ptr_q <= reg_wdata;
                    RSEL_SRC: src_q <= reg_wdata;
                    RSEL_TGT: tgt_q <= reg_wdata;
                    RSEL_CMD: cmd_q <= reg_wdata;
                    default: ;
                endcase
            end
            case (st)
                ST_IDLE: begin
                    if (go) begin
                        if (nofetch) begin
                            st <= ST_CHECK;
                        end else begin
                            fbase <= {ptr_q[WORD_W-1:4], 4'b0000};
                            widx  <= '0;
                            st    <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            st <= ST_IDLE;
                        end else begin
                            case (widx)
                                2'd0: ptr_q <= mem_rdata;
                                2'd1: src_q <= mem_rdata;
                                2'd2: tgt_q <= mem_rdata;
                                default: begin
                                    cmd_q <= mem_rdata;
                                    st    <= ST_CHECK;
                                end
                            endcase
                            widx <= widx + 2'd1;
                        end
                    end
                end
                ST_CHECK: begin
                    if (len == '0) begin
                        st <= ST_DONE;
                    end else if (!flow || dreq) begin
                        bleft <= burst_words(cmd_q[CB_BURST_LO+1:CB_BURST_LO]);
                        st    <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            st <= ST_IDLE;
                        end else begin
                            data_q <= mem_rdata;
                            st     <= ST_WRITE;
                        end
                    end
                end
                ST_WRITE: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            st <= ST_IDLE;
                        end else begin
                            if (cmd_q[CB_INC_SRC]) src_q <= src_q + ADDR_STEP;
                            if (cmd_q[CB_INC_TGT]) tgt_q <= tgt_q + ADDR_STEP;
                            cmd_q[LEN_W-1:0] <= (len > LEN_STEP) ? len - LEN_STEP : '0;
                            bleft <= bleft - 4'd1;
                            st    <= (len > LEN_STEP && bleft > 4'd1) ? ST_READ : ST_CHECK;
                        end
                    end
                end
                ST_DONE: begin
                    if (nofetch || ptr_q[0]) begin
                        st <= ST_IDLE;
                    end else begin
                        fbase <= {ptr_q[WORD_W-1:4], 4'b0000};
                        widx  <= '0;
                        st    <= ST_FETCH;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = (st == ST_FETCH) || (st == ST_READ) || (st == ST_WRITE);
        mem_we    = (st == ST_WRITE);
        mem_wdata = data_q;
        case (st)
            ST_FETCH: mem_addr = fbase + {{(WORD_W-IDX_W-2){1'b0}}, widx, 2'b00};
            ST_WRITE: mem_addr = tgt_q;
            default:  mem_addr = src_q;
        endcase
    end

    always_comb begin
        evt.set_start  = !halt && (
            (st == ST_FETCH && mem_ack && !mem_err && widx == 2'd3 && mem_rdata[CB_START_IE]) ||
            (st == ST_IDLE && go && nofetch && cmd_q[CB_START_IE]));
        evt.set_end    = !halt && (st == ST_DONE) && cmd_q[CB_END_IE];
        evt.set_buserr = !halt && mem_req && mem_ack && mem_err;
    end

    // R3: an unanswered request keeps its address
    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && !halt) |=> (mem_req && $stable(mem_addr)));
    // R4: every completed word shortens the remaining length
    p_len_down_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WRITE && mem_ack && !mem_err && !halt) |=> (len < $past(len)));
    // R5: a stop bit in the next pointer ends the run
    p_stop_bit_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DONE && ptr_q[0] && !halt) |=> (st == ST_IDLE));
    // R7: no burst begins while the request input is low
    p_flow_wait_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CHECK && flow && !dreq && len != '0 && !halt) |=> !mem_req);
endmodule

// File: rtl/dchain_top.sv
module dchain_top
    import dchain_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        dreq,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    input  logic        mem_err,
    output logic        irq
);
    logic              go, halt, nofetch_eff, busy, wr_ctrl;
    logic [WORD_W-1:0] ctrl_word, ptr_q, src_q, tgt_q, cmd_q;
    evt_t              evt;
    ctrl_wr_t          wbits;

    assign wr_ctrl = reg_we && (reg_addr == RSEL_CTRL);
    assign wbits   = '{run:        reg_wdata[SB_RUN],
                       nofetch:    reg_wdata[SB_NOFETCH],
                       stop_ie:    reg_wdata[SB_STOP_IE],
                       clr_end:    reg_wdata[SB_END],
                       clr_start:  reg_wdata[SB_START],
                       clr_buserr: reg_wdata[SB_BUSERR]};

    dchain_csr u_csr (
        .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wbits(wbits), .busy(busy),
        .dreq(dreq), .evt(evt), .go(go), .halt(halt), .nofetch_eff(nofetch_eff),
        .ctrl_word(ctrl_word), .irq(irq)
    );

    dchain_seq u_seq (
        .clk(clk), .rst(rst), .go(go), .halt(halt), .nofetch(nofetch_eff),
        .reg_we(reg_we), .reg_sel(reg_addr), .reg_wdata(reg_wdata), .dreq(dreq),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .busy(busy), .ptr_q(ptr_q), .src_q(src_q), .tgt_q(tgt_q), .cmd_q(cmd_q), .evt(evt)
    );

    always_comb begin
        case (reg_addr)
            RSEL_CTRL: reg_rdata = ctrl_word;
            RSEL_PTR:  reg_rdata = ptr_q;
            RSEL_SRC:  reg_rdata = src_q;
            RSEL_TGT:  reg_rdata = tgt_q;
            RSEL_CMD:  reg_rdata = cmd_q;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: tb/test_dchain_top.sv
`timescale 1ns/1ps
module test_dchain_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        dreq = 1'b0;
    logic        mem_req, mem_we, mem_ack, mem_err, irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic [31:0] mem [0:1023];
    logic [7:0]  lfsr = 8'h5B;
    logic        stall_en = 1'b0;
    logic        stall;

    int n_tests = 0;
    int n_fail  = 0;
    int wr_count = 0;
    int cyc = 0;
    logic [31:0] exp_a[$];
    logic [31:0] exp_d[$];

    always #2.5 clk = ~clk;

    assign stall     = stall_en & lfsr[0];
    assign mem_ack   = mem_req & ~stall;
    assign mem_err   = mem_ack & mem_addr[31];
    assign mem_rdata = mem[mem_addr[11:2]];

    always @(posedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

    dchain_top i_dchain_top (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dreq(dreq), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_err(mem_err), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // per-clock reference comparison of every target write
    always @(negedge clk) begin
        if (!rst && mem_req && mem_we && mem_ack && !mem_err) begin
            wr_count++;
            if (exp_a.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL R3: unexpected write actual %h expected none", mem_addr);
            end else begin
                check("R3 write address", mem_addr, exp_a[0]);
                check("R3 write data", mem_wdata, exp_d[0]);
                void'(exp_a.pop_front());
                void'(exp_d.pop_front());
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic put_desc(input logic [31:0] at, input logic [31:0] nxt,
                            input logic [31:0] s, input logic [31:0] t, input logic [31:0] c);
        mem[at[11:2]]       = nxt;
        mem[at[11:2] + 1]   = s;
        mem[at[11:2] + 2]   = t;
        mem[at[11:2] + 3]   = c;
    endtask

    task automatic expect_words(input logic [31:0] s, input logic [31:0] t, input int bytes,
                                input bit inc_s, input bit inc_t);
        logic [31:0] sa = s;
        logic [31:0] ta = t;
        for (int k = 0; k < bytes / 4; k++) begin
            exp_a.push_back(ta);
            exp_d.push_back(mem[sa[11:2]]);
            if (inc_s) sa = sa + 4;
            if (inc_t) ta = ta + 4;
        end
    endtask

    task automatic wait_stopped(input string req);
        logic [31:0] v;
        int guard = 0;
        rd(3'd0, v);
        while (!v[3] && guard < 2000) begin
            rd(3'd0, v);
            guard++;
        end
        check(req, {31'd0, v[3]}, 32'd1);
    endtask

    task automatic idle_cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        int base;
        int guard;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h5A00_0000 | i;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(3'd0, v);
        check("R1 control after reset", v, 32'h0000_0008);
        check("R1 irq after reset", {31'd0, irq}, 32'd0);
        check("R1 mem_req after reset", {31'd0, mem_req}, 32'd0);

        // single descriptor, both addresses increment, end interrupt
        put_desc(32'h100, 32'h0000_0001, 32'h040, 32'h800, 32'hC020_0010);
        expect_words(32'h040, 32'h800, 16, 1, 1);
        wr(3'd1, 32'h100);
        wr(3'd0, 32'h8000_0000);
        wait_stopped("R5 single descriptor stops");
        rd(3'd0, v); check("R6 end flag and stopped", v, 32'h0000_000C);
        rd(3'd2, v); check("R4 source advanced", v, 32'h050);
        rd(3'd3, v); check("R4 target advanced", v, 32'h810);
        rd(3'd1, v); check("R2 pointer holds next pointer", v, 32'h0000_0001);
        rd(3'd4, v); check("R4 length counted to zero", v, 32'hC020_0000);
        check("R6 irq with end flag", {31'd0, irq}, 32'd1);
        check("R3 all single writes seen", exp_a.size(), 0);

        // R6: writing 0 keeps the flag, writing the read value clears it
        wr(3'd0, 32'h0000_0000);
        rd(3'd0, v); check("R6 zero write keeps flag", v, 32'h0000_000C);
        wr(3'd0, v);
        rd(3'd0, v); check("R6 write-back clears flag", v, 32'h0000_0008);
        check("R6 irq cleared", {31'd0, irq}, 32'd0);

        // three-descriptor chain under memory stalls
        stall_en = 1'b1;
        put_desc(32'h100, 32'h120, 32'h080, 32'h900, 32'hC000_0008);
        put_desc(32'h120, 32'h140, 32'h0A0, 32'hA00, 32'h8000_C00C);
        put_desc(32'h140, 32'h001, 32'h0C0, 32'hA80, 32'hC064_0004);
        expect_words(32'h080, 32'h900, 8, 1, 1);
        expect_words(32'h0A0, 32'hA00, 12, 1, 0);
        expect_words(32'h0C0, 32'hA80, 4, 1, 1);
        wr(3'd1, 32'h100);
        wr(3'd0, 32'h8000_0000);
        wait_stopped("R5 chain stops at stop bit");
        rd(3'd0, v); check("R6 start and end flags after chain", v, 32'h0000_000E);
        rd(3'd2, v); check("R4 chain final source", v, 32'h0C4);
        rd(3'd3, v); check("R4 chain final target", v, 32'hA84);
        check("R2 chain descriptors all followed", exp_a.size(), 0);
        wr(3'd0, 32'h0000_0007);
        stall_en = 1'b0;

        // R7: flow-controlled transfer, 2-word bursts, fixed target
        put_desc(32'h180, 32'h001, 32'h040, 32'hB00, 32'h9001_0010);
        expect_words(32'h040, 32'hB00, 16, 1, 0);
        base = wr_count;
        wr(3'd1, 32'h180);
        wr(3'd0, 32'h8000_0000);
        idle_cycles(40);
        check("R7 no write without request", wr_count - base, 0);
        rd(3'd0, v); check("R7 running, request bit low", v & 32'h8000_0108, 32'h8000_0000);
        rd(3'd3, v); check("R2 target loaded", v, 32'hB00);
        rd(3'd4, v); check("R2 command loaded", v, 32'h9001_0010);
        wr(3'd2, 32'h0000_03FC);
        rd(3'd2, v); check("R12 source write ignored while running", v, 32'h040);
        @(negedge clk); dreq = 1'b1;
        @(negedge clk); dreq = 1'b0;
        idle_cycles(20);
        check("R7 one burst of two words", wr_count - base, 2);
        rd(3'd2, v); check("R12 live source shows progress", v, 32'h048);
        @(negedge clk); dreq = 1'b1;
        rd(3'd0, v); check("R7 request bit follows dreq", {31'd0, v[8]}, 32'd1);
        wait_stopped("R7 flow transfer completes");
        dreq = 1'b0;
        check("R7 all flow words written", wr_count - base, 4);

        // R8/R9: looping chain, then halt
        put_desc(32'h1C0, 32'h1E0, 32'h040, 32'hC00, 32'hC020_0008);
        put_desc(32'h1E0, 32'h1C0, 32'h060, 32'hC40, 32'hC020_0004);
        for (int loop = 0; loop < 40; loop++) begin
            expect_words(32'h040, 32'hC00, 8, 1, 1);
            expect_words(32'h060, 32'hC40, 4, 1, 1);
        end
        base = wr_count;
        wr(3'd1, 32'h1C0);
        wr(3'd0, 32'h8000_0000);
        guard = 0;
        while (wr_count - base < 7 && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        rd(3'd0, v); check("R8 loop still running with end flag", v & 32'h8000_0004, 32'h8000_0004);
        wr(3'd0, 32'h0000_0000);
        check("R9 no request after halt", {31'd0, mem_req}, 32'd0);
        rd(3'd0, v); check("R9 stopped after halt", v & 32'h8000_0008, 32'h0000_0008);
        base = wr_count;
        idle_cycles(10);
        check("R9 no writes after halt", wr_count - base, 0);
        exp_a.delete();
        exp_d.delete();
        wr(3'd0, 32'h0000_0007);

        // R10: no-fetch mode uses registers directly
        rd(3'd1, v); base = int'(v);
        wr(3'd2, 32'h040);
        wr(3'd3, 32'hD00);
        wr(3'd4, 32'hC000_0008);
        expect_words(32'h040, 32'hD00, 8, 1, 1);
        wr(3'd0, 32'hC000_0000);
        wait_stopped("R10 no-fetch run stops");
        rd(3'd0, v); check("R10 control after no-fetch run", v, 32'h4000_0008);
        rd(3'd3, v); check("R10 target advanced", v, 32'hD08);
        rd(3'd1, v); check("R10 pointer untouched", v, 32'(base));
        check("R10 writes seen", exp_a.size(), 0);
        wr(3'd0, 32'h0000_0000);

        // R11: error on data read, then on descriptor fetch
        put_desc(32'h200, 32'h001, 32'h8000_0000, 32'hD80, 32'hC000_0008);
        wr(3'd1, 32'h200);
        wr(3'd0, 32'h8000_0000);
        wait_stopped("R11 data error stops channel");
        rd(3'd0, v); check("R11 bus error flag on read", v, 32'h0000_0009);
        check("R11 irq on bus error", {31'd0, irq}, 32'd1);
        wr(3'd0, 32'h0000_0001);
        wr(3'd1, 32'h8000_0000);
        wr(3'd0, 32'h8000_0000);
        wait_stopped("R11 fetch error stops channel");
        rd(3'd0, v); check("R11 bus error flag on fetch", v, 32'h0000_0009);
        wr(3'd0, 32'h0000_0001);
        rd(3'd0, v); check("R6 bus error cleared", v, 32'h0000_0008);

        // R13: stop interrupt enable while stopped
        wr(3'd0, 32'h2000_0000);
        rd(3'd0, v); check("R13 control with stop enable", v, 32'h2000_0008);
        check("R13 irq while stopped", {31'd0, irq}, 32'd1);
        wr(3'd0, 32'h0000_0000);
        check("R13 irq off after disable", {31'd0, irq}, 32'd0);

        finish_run();
    end
endmodule